// File: doc/BRIEF.md
# Sixteen-Bit Execute-Stage ALU with Built-In Immediate Widening

This block is the arithmetic and logic unit of a small pipelined processor's execute stage. It takes a 16-bit first operand from the register read bus and a second operand that comes from one of two places. It can be the second register read bus, or a 5-bit immediate field from the instruction, widened to 16 bits. It produces a 16-bit result together with a sign flag and a zero flag.

The widening of the immediate is done inside the block. The caller chooses the widening mode. Arithmetic immediate instructions ask for sign extension. Logic immediate instructions ask for zero extension.

The unit supports eight functions, picked by a 3-bit function code: subtract, add, and six bitwise functions. The bitwise set includes the inverted forms NOR, NAND and XNOR. The block holds no state. Its result and both flags follow the inputs within the same clock cycle, so the pipeline register that follows can capture all three together. Carry-out and overflow are dropped and not reported.

Top module: `alu16_exec`

## Requirements
- R1: The function code `fn_sel` selects the bitwise functions as follows: 010 gives ~(A|B), 011 gives A|B, 100 gives ~(A&B), 101 gives A&B, 110 gives ~(A^B) and 111 gives A^B.
- R2: Function code 000 gives A minus B, modulo 2^16.
- R3: Function code 001 gives A plus B, modulo 2^16. The carry out of bit 15 is discarded.
- R4: When `b_from_imm` is 1, operand B is the widened immediate. When it is 0, operand B is `bus_b`.
- R5: When `imm_signed` is 1, the immediate is sign-extended: bit 4 fills bits 15..5. For example, 5'b11011 becomes 16'hFFFB.
- R6: When `imm_signed` is 0, bits 15..5 of the widened immediate are 0. For example, 5'b01110 becomes 16'h000E and 5'b11011 becomes 16'h001B.
- R7: `sign_out` always equals bit 15 of `result`, for every function.
- R8: `zero_out` is 1 exactly when all 16 bits of `result` are 0, for every function.
- R9: The operand source that is not selected has no effect. `bus_b` is ignored while `b_from_imm` is 1, and `imm_field` and `imm_signed` are ignored while it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_a | input | 16 | First operand (A) |
| bus_b | input | 16 | Register value for operand B |
| imm_field | input | 5 | Immediate field from the instruction |
| fn_sel | input | 3 | Function code |
| b_from_imm | input | 1 | 1: operand B is the widened immediate |
| imm_signed | input | 1 | 1: sign extension, 0: zero extension |
| result | output | 16 | Function result |
| sign_out | output | 1 | Bit 15 of the result |
| zero_out | output | 1 | 1 when the result is all zeros |

## Verification
Every result of this block, and both flags, is due zero cycles after its stimulus: they are valid in the same cycle in which the inputs change. The bench changes the inputs just after a falling clock edge. It samples the outputs a quarter period later, well before the next rising edge, so that no check depends on edge ordering.

The bench sweeps every function code against all 32 immediate values in both widening modes, over a set of edge-value first operands. It then sweeps a grid of bus values. For each sweep it computes the expected result and flags arithmetically. Finally, it toggles the unselected source while holding the selected one, and confirms that the outputs do not move.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned IMM_W  = 5;
    localparam int unsigned FN_W   = 3;

    // Function codes; the order is fixed by the instruction decoder.
    typedef enum logic [FN_W-1:0] {
        FN_SUB  = 3'b000,
        FN_ADD  = 3'b001,
        FN_NOR  = 3'b010,
        FN_OR   = 3'b011,
        FN_NAND = 3'b100,
        FN_AND  = 3'b101,
        FN_XNOR = 3'b110,
        FN_XOR  = 3'b111
    } alu_fn_e;
endpackage

// File: rtl/alu16_imm_ext.sv
`timescale 1ns/1ps
module alu16_imm_ext #(
    parameter int unsigned W  = alu16_pkg::DATA_W,
    parameter int unsigned IW = alu16_pkg::IMM_W
) (
    input  logic [IW-1:0] imm,
    input  logic          sign_mode,
    output logic [W-1:0]  wide
);
    localparam int unsigned PAD_W = W - IW;

    logic fill_bit;

    always_comb begin
        fill_bit = sign_mode & imm[IW-1];
        wide     = {{PAD_W{fill_bit}}, imm};

        // Sign mode keeps the numeric value of the signed field.
        AST_SIGN_WIDEN_VALUE: assert (!sign_mode || int'($signed(wide)) == int'($signed(imm))); // R5
        // Zero mode leaves nothing above the field.
        AST_ZERO_WIDEN_HIGH: assert (sign_mode || (wide >> IW) == '0); // R6
    end
endmodule

// File: rtl/alu16_core.sv
`timescale 1ns/1ps
module alu16_core
    import alu16_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            FN_SUB:  y = opa - opb;
            FN_ADD:  y = opa + opb;
            FN_NOR:  y = ~(opa | opb);
            FN_OR:   y = opa | opb;
            FN_NAND: y = ~(opa & opb);
            FN_AND:  y = opa & opb;
            FN_XNOR: y = ~(opa ^ opb);
            FN_XOR:  y = opa ^ opb;
            default: y = '0;
        endcase

        AST_SUB_INVERTS: assert (fn != FN_SUB || (y + opb) == opa); // R2
        AST_ADD_INVERTS: assert (fn != FN_ADD || (y - opb) == opa); // R3
        AST_NAND_COMPLEMENT: assert (fn != FN_NAND || (y ^ (opa & opb)) == '1); // R1
        AST_NOR_DISJOINT: assert (fn != FN_NOR || (y & (opa | opb)) == '0); // R1
    end
endmodule

// File: rtl/alu16_flags.sv
`timescale 1ns/1ps
module alu16_flags #(
    parameter int unsigned W = alu16_pkg::DATA_W
) (
    input  logic [W-1:0] y,
    output logic         neg,
    output logic         nil
);
    always_comb begin
        neg = y[W-1];
        nil = ~|y;
    end
endmodule

// File: rtl/alu16_exec.sv
`timescale 1ns/1ps
module alu16_exec
    import alu16_pkg::*;
(
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [FN_W-1:0]   fn_sel,
    input  logic              b_from_imm,
    input  logic              imm_signed,
    output logic [DATA_W-1:0] result,
    output logic              sign_out,
    output logic              zero_out
);
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] operand_b;
    alu_fn_e           fn_code;

    alu16_imm_ext #(.W(DATA_W), .IW(IMM_W)) u_ext (
        .imm       (imm_field),
        .sign_mode (imm_signed),
        .wide      (imm_wide)
    );

    always_comb begin
        fn_code   = alu_fn_e'(fn_sel);
        operand_b = b_from_imm ? imm_wide : bus_b;
    end

    alu16_core #(.W(DATA_W)) u_core (
        .opa (bus_a),
        .opb (operand_b),
        .fn  (fn_code),
        .y   (result)
    );

    alu16_flags #(.W(DATA_W)) u_flags (
        .y   (result),
        .neg (sign_out),
        .nil (zero_out)
    );

    // The flag logic and the function logic are separate units; check they agree.
    always_comb begin
        AST_SIGN_TRACKS_MSB: assert (sign_out == result[DATA_W-1]); // R7
        AST_ZERO_ONLY_WHEN_CLEAR: assert (!zero_out || result == '0); // R8
        AST_CLEAR_RAISES_ZERO: assert (zero_out || result != '0); // R8
    end
endmodule

// File: tb/alu16_exec_test.sv
`timescale 1ns/1ps
module alu16_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_a = '0;
    logic [15:0] bus_b = '0;
    logic [4:0]  imm_field = '0;
    logic [2:0]  fn_sel = '0;
    logic        b_from_imm = 1'b0;
    logic        imm_signed = 1'b0;
    logic [15:0] result;
    logic        sign_out;
    logic        zero_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alu16_exec uut (
        .bus_a      (bus_a),
        .bus_b      (bus_b),
        .imm_field  (imm_field),
        .fn_sel     (fn_sel),
        .b_from_imm (b_from_imm),
        .imm_signed (imm_signed),
        .result     (result),
        .sign_out   (sign_out),
        .zero_out   (zero_out)
    );

    function automatic logic [15:0] pattern(input int i);
        case (i % 8)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h7FFF;
            4: return 16'h1234;
            5: return 16'h0005;
            6: return 16'hA5A5;
            default: return 16'h0001;
        endcase
    endfunction

    function automatic logic [15:0] widen(input logic [4:0] imm, input logic sgn);
        int v;
        v = int'(imm);
        if (sgn && v >= 16) v = v - 32;
        return 16'(v);
    endfunction

    function automatic logic [15:0] model(input logic [2:0] fn, input logic [15:0] a,
                                          input logic [15:0] b);
        case (fn)
            3'b000: return 16'((int'(a) - int'(b)) & 32'hFFFF);
            3'b001: return 16'((int'(a) + int'(b)) & 32'hFFFF);
            3'b010: return ~(a | b);
            3'b011: return a | b;
            3'b100: return ~(a & b);
            3'b101: return a & b;
            3'b110: return ~(a ^ b);
            default: return a ^ b;
        endcase
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (fn=%b a=%h b=%h imm=%b src=%b sgn=%b)",
                     tag, act, exp, fn_sel, bus_a, bus_b, imm_field, b_from_imm, imm_signed);
        end
    endtask

    task automatic apply(input logic [2:0] fn, input logic [15:0] a, input logic [15:0] b,
                         input logic [4:0] imm, input logic src, input logic sgn);
        @(negedge clk);
        fn_sel = fn; bus_a = a; bus_b = b; imm_field = imm;
        b_from_imm = src; imm_signed = sgn;
        #5;   // same-cycle result, sampled before the next rising edge
    endtask

    task automatic check_all(input logic [15:0] b_eff, input string tag);
        logic [15:0] exp;
        string ftag;
        exp = model(fn_sel, bus_a, b_eff);
        ftag = (fn_sel == 3'b000) ? "R2" : (fn_sel == 3'b001) ? "R3" : "R1";
        check16({ftag, "/", tag}, result, exp);
        check16("R7 sign", {15'd0, sign_out}, {15'd0, exp[15]});
        check16("R8 zero", {15'd0, zero_out}, {15'd0, exp == 16'h0000});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state inputs: all zero, subtract -> zero result, zero flag high (R2, R8)
        apply(3'b000, 16'h0000, 16'h0000, 5'd0, 1'b0, 1'b0);
        check16("R8 idle result", result, 16'h0000);
        check16("R8 idle zero", {15'd0, zero_out}, 16'd1);

        // Documented widening examples (R5, R6), seen through ADD with A=0
        apply(3'b001, 16'h0000, 16'h0000, 5'b11011, 1'b1, 1'b1);
        check16("R5 11011 signed", result, 16'hFFFB);
        apply(3'b001, 16'h0000, 16'h0000, 5'b01110, 1'b1, 1'b1);
        check16("R5 01110 signed", result, 16'h000E);
        apply(3'b001, 16'h0000, 16'h0000, 5'b01110, 1'b1, 1'b0);
        check16("R6 01110 zero", result, 16'h000E);
        apply(3'b001, 16'h0000, 16'h0000, 5'b11011, 1'b1, 1'b0);
        check16("R6 11011 zero", result, 16'h001B);

        // Carry out of bit 15 discarded (R3), borrow wraps (R2)
        apply(3'b001, 16'hFFFF, 16'h0001, 5'd0, 1'b0, 1'b0);
        check16("R3 wrap", result, 16'h0000);
        check16("R8 wrap zero", {15'd0, zero_out}, 16'd1);
        apply(3'b000, 16'h0000, 16'h0001, 5'd0, 1'b0, 1'b0);
        check16("R2 borrow", result, 16'hFFFF);
        check16("R7 borrow sign", {15'd0, sign_out}, 16'd1);

        // Immediate sweep: every function, every field value, both modes (R4, R5, R6)
        for (int f = 0; f < 8; f++)
            for (int s = 0; s < 2; s++)
                for (int v = 0; v < 32; v++)
                    for (int ai = 0; ai < 8; ai++) begin
                        apply(3'(f), pattern(ai), pattern(ai + 3), 5'(v), 1'b1, 1'(s));
                        check_all(widen(5'(v), 1'(s)), (s != 0) ? "R5 R4 imm" : "R6 R4 imm");
                    end

        // Register-operand sweep (R4)
        for (int f = 0; f < 8; f++)
            for (int ai = 0; ai < 8; ai++)
                for (int bi = 0; bi < 8; bi++) begin
                    apply(3'(f), pattern(ai), pattern(bi), 5'(ai * 3 + bi), 1'b0, 1'(bi));
                    check_all(pattern(bi), "R4 bus");
                end

        // Unselected source has no effect (R9)
        for (int f = 0; f < 8; f++) begin
            apply(3'(f), 16'h3C5A, 16'h0000, 5'b10110, 1'b1, 1'b1);
            r0 = result;
            apply(3'(f), 16'h3C5A, 16'hFFFF, 5'b10110, 1'b1, 1'b1);
            check16("R9 bus_b ignored", result, r0);
            apply(3'(f), 16'h3C5A, 16'h9E37, 5'b00000, 1'b0, 1'b0);
            r0 = result;
            apply(3'(f), 16'h3C5A, 16'h9E37, 5'b11111, 1'b0, 1'b1);
            check16("R9 imm ignored", result, r0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule